// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit linear address into a 36-bit physical address by walking page tables held in memory. A walk takes three steps. The top table has only four slots and is picked by the two highest address bits. The second step reads a directory. The third step reads a page table. Every table slot is 64 bits wide. For each step the walker places one read on a memory read port, then waits for the returned entry before it decides what to do next.

A configuration register holds the base of the top table. The walk ends in one of two ways. It may produce a translated address, either for a 4 KB page or, when a directory entry marks a large page, for a 2 MB page. Otherwise it ends in a page fault that reports the level whose entry was not present. Only one walk runs at a time. While a walk is in progress the request side shows not-ready.

Top module: `xlat_walker3`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is 1, `mem_req_valid` is 0 and `done_valid` is 0.
- R2: The first read goes to `{root[35:5], 5'b0} + lin[31:30]*8`. `root` is the value last written through `cfg_root_we`/`cfg_root_data`, with bits 4:0 of the written data ignored. The walker takes the root value when it accepts a request, so a root write during a walk changes only later walks. Every read address is 8-byte aligned.
- R3: The second read goes to `{e0[35:12], 12'b0} + lin[29:21]*8`. The third read goes to `{e1[35:12], 12'b0} + lin[20:12]*8`. Here e0 and e1 are the entries returned for the first and second reads.
- R4: When all three entries are present, the walk makes exactly three reads. It reports `done_fault`=0, `done_level`=2 and `done_phys = {e2[35:12], lin[11:0]}`.
- R5: A present directory entry (e1) with bit 7 set marks a 2 MB page. The walk then stops after two reads, with `done_level`=1 and `done_phys = {e1[35:21], lin[20:0]}`. Bit 7 of a top-level or page-table entry has no effect.
- R6: Bit 0 of each entry is its present bit. If it is 0 at level k (0 = top table, 1 = directory, 2 = page table), the walk makes no further reads and reports `done_fault`=1, `done_level`=k and `done_phys`=0.
- R7: From the cycle a request is accepted until the walk's `done_valid` cycle, `req_ready` is 0. Requests offered in that time are ignored and do not change the walk in progress.
- R8: `mem_req_valid` stays high, with `mem_req_addr` stable, until `mem_req_ready` is seen. Each accepted request produces exactly one `done_valid` cycle, and `req_ready` returns to 1 in the next cycle.
- R9: Entry bits 63:36 are ignored and have no effect on any read address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_root_we | input | 1 | Write strobe for the top-table base register |
| cfg_root_data | input | 36 | New top-table base; bits 4:0 ignored |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Returned entry is valid this cycle |
| mem_rsp_data | input | 64 | Returned table entry |
| done_valid | output | 1 | One-cycle pulse marking the end of a walk |
| done_fault | output | 1 | Walk ended in a page fault |
| done_level | output | 2 | Level of the final entry read (0 top, 1 directory, 2 table) |
| done_phys | output | 36 | Translated physical address (0 on fault) |

## Verification
The bench builds the walker with its default parameters: a 32-bit linear address split 2/9/9/12, a 36-bit physical address and 64-bit entries. With only four top-table slots, a few random addresses reach every top slot. The 36-bit width puts table bases and results above the 4 GB line, and the 64-bit entries leave 28 upper bits that the bench fills with random data to show they are ignored. Random tables mix present, absent and large-page entries, and the memory stalls for random lengths of time, so each fault level, both page sizes and the request hold path are all covered.

// File: rtl/xw_pkg.sv
package xw_pkg;
  // Walk controller states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

  // Level codes, also reported on done_level.
  localparam logic [1:0] LV_PTR = 2'd0;
  localparam logic [1:0] LV_DIR = 2'd1;
  localparam logic [1:0] LV_TBL = 2'd2;
endpackage

// File: rtl/xw_index_sel.sv
module xw_index_sel #(
  parameter int LIN_W      = 32,
  parameter int PHYS_W     = 36,
  parameter int TOP_IDX_W  = 2,
  parameter int MID_IDX_W  = 9,
  parameter int LEAF_IDX_W = 9,
  parameter int OFS_W      = 12,
  parameter int ENT_SHIFT  = 3
) (
  input  logic [LIN_W-1:0]  lin,
  input  logic [1:0]        level,
  input  logic [PHYS_W-1:0] base,
  output logic [PHYS_W-1:0] slot_addr
);
  import xw_pkg::*;

  localparam int IDX_W = (MID_IDX_W > LEAF_IDX_W) ? MID_IDX_W : LEAF_IDX_W;
  localparam int MID_LSB = OFS_W + LEAF_IDX_W;

  // Table base plus index scaled by entry size.
  function automatic logic [PHYS_W-1:0] slot_of(input logic [PHYS_W-1:0] b,
                                                 input logic [IDX_W-1:0] idx);
    return b + (PHYS_W'(idx) << ENT_SHIFT);
  endfunction

  logic [IDX_W-1:0] idx_sel;

  always_comb begin
    case (level)
      LV_PTR:  idx_sel = IDX_W'(lin[LIN_W-1 -: TOP_IDX_W]);
      LV_DIR:  idx_sel = IDX_W'(lin[MID_LSB +: MID_IDX_W]);
      default: idx_sel = IDX_W'(lin[OFS_W +: LEAF_IDX_W]);
    endcase
  end

  assign slot_addr = slot_of(base, idx_sel);

  logic unused_lo;
  assign unused_lo = ^lin[OFS_W-1:0];
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec #(
  parameter int LIN_W       = 32,
  parameter int PHYS_W      = 36,
  parameter int ENT_W       = 64,
  parameter int OFS_W       = 12,
  parameter int LEAF_IDX_W  = 9,
  parameter int PRESENT_BIT = 0,
  parameter int LARGE_BIT   = 7
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic [LIN_W-1:0]  lin,
  input  logic [1:0]        level,
  output logic              present,
  output logic              is_final,
  output logic [PHYS_W-1:0] next_base,
  output logic [PHYS_W-1:0] phys
);
  import xw_pkg::*;

  localparam int BIG_OFS_W = OFS_W + LEAF_IDX_W;

  function automatic logic [PHYS_W-1:0] small_page(input logic [ENT_W-1:0] e,
                                                   input logic [LIN_W-1:0] a);
    return {e[PHYS_W-1:OFS_W], a[OFS_W-1:0]};
  endfunction

  function automatic logic [PHYS_W-1:0] big_page(input logic [ENT_W-1:0] e,
                                                 input logic [LIN_W-1:0] a);
    return {e[PHYS_W-1:BIG_OFS_W], a[BIG_OFS_W-1:0]};
  endfunction

  logic big_hit;

  assign present   = entry[PRESENT_BIT];
  assign big_hit   = (level == LV_DIR) && entry[LARGE_BIT];
  assign is_final  = big_hit || (level == LV_TBL);
  assign next_base = {entry[PHYS_W-1:OFS_W], OFS_W'(0)};
  assign phys      = big_hit ? big_page(entry, lin) : small_page(entry, lin);

  logic unused_bits;
  assign unused_bits = ^{entry[ENT_W-1:PHYS_W], entry[OFS_W-1:0]};
endmodule

// File: rtl/xlat_walker3.sv
module xlat_walker3 #(
  parameter int LIN_W        = 32,
  parameter int PHYS_W       = 36,
  parameter int ENT_W        = 64,
  parameter int TOP_IDX_W    = 2,
  parameter int MID_IDX_W    = 9,
  parameter int LEAF_IDX_W   = 9,
  parameter int OFS_W        = 12,
  parameter int ROOT_ALIGN_W = 5,
  parameter int PRESENT_BIT  = 0,
  parameter int LARGE_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_root_we,
  input  logic [PHYS_W-1:0] cfg_root_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LIN_W-1:0]  req_lin,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PHYS_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic [1:0]        done_level,
  output logic [PHYS_W-1:0] done_phys
);
  import xw_pkg::*;

  localparam int ENT_SHIFT = $clog2(ENT_W / 8);

  walk_st_e          st_q;
  logic [1:0]        lvl_q;
  logic [LIN_W-1:0]  lin_q;
  logic [PHYS_W-1:0] base_q;
  logic [PHYS_W-1:0] root_q;
  logic              res_fault_q;
  logic [1:0]        res_level_q;
  logic [PHYS_W-1:0] res_phys_q;

  // Named internal events, observed by the bound checker.
  logic accept_w;
  logic rsp_take_w;
  logic walk_end_w;

  logic              ent_present;
  logic              ent_final;
  logic [PHYS_W-1:0] ent_next_base;
  logic [PHYS_W-1:0] ent_phys;
  logic [PHYS_W-1:0] slot_addr;

  xw_index_sel #(
    .LIN_W(LIN_W), .PHYS_W(PHYS_W), .TOP_IDX_W(TOP_IDX_W),
    .MID_IDX_W(MID_IDX_W), .LEAF_IDX_W(LEAF_IDX_W), .OFS_W(OFS_W),
    .ENT_SHIFT(ENT_SHIFT)
  ) u_idx (
    .lin(lin_q), .level(lvl_q), .base(base_q), .slot_addr(slot_addr)
  );

  xw_entry_dec #(
    .LIN_W(LIN_W), .PHYS_W(PHYS_W), .ENT_W(ENT_W), .OFS_W(OFS_W),
    .LEAF_IDX_W(LEAF_IDX_W), .PRESENT_BIT(PRESENT_BIT), .LARGE_BIT(LARGE_BIT)
  ) u_dec (
    .entry(mem_rsp_data), .lin(lin_q), .level(lvl_q),
    .present(ent_present), .is_final(ent_final),
    .next_base(ent_next_base), .phys(ent_phys)
  );

  assign req_ready     = (st_q == ST_IDLE);
  assign accept_w      = req_valid && req_ready;
  assign rsp_take_w    = (st_q == ST_WAIT) && mem_rsp_valid;
  assign walk_end_w    = rsp_take_w && (!ent_present || ent_final);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = slot_addr;
  assign done_valid    = (st_q == ST_DONE);
  assign done_fault    = res_fault_q;
  assign done_level    = res_level_q;
  assign done_phys     = res_phys_q;

  // Top-table base register, stored already aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (cfg_root_we) begin
      root_q <= {cfg_root_data[PHYS_W-1:ROOT_ALIGN_W], ROOT_ALIGN_W'(0)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lvl_q       <= LV_PTR;
      lin_q       <= '0;
      base_q      <= '0;
      res_fault_q <= 1'b0;
      res_level_q <= LV_PTR;
      res_phys_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept_w) begin
            lin_q  <= req_lin;
            base_q <= root_q;
            lvl_q  <= LV_PTR;
            st_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (walk_end_w) begin
            res_fault_q <= !ent_present;
            res_level_q <= lvl_q;
            res_phys_q  <= ent_present ? ent_phys : '0;
            st_q        <= ST_DONE;
          end else if (rsp_take_w) begin
            base_q <= ent_next_base;
            lvl_q  <= lvl_q + 2'd1;
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_root;
  assign unused_root = ^cfg_root_data[ROOT_ALIGN_W-1:0];
endmodule

// File: rtl/xlat_walker3_chk.sv
module xlat_walker3_chk #(
  parameter int PHYS_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PHYS_W-1:0] mem_req_addr,
  input logic              rsp_present,
  input logic              done_valid,
  input logic              done_fault,
  input logic [1:0]        done_level,
  input logic [PHYS_W-1:0] done_phys,
  input logic              accept_w,
  input logic              rsp_take_w,
  input logic              walk_end_w
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !done_valid));

  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_next_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take_w && !walk_end_w) |=> mem_req_valid);

  assert_success_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_level != 2'd0));

  assert_absent_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take_w && !rsp_present) |=> (done_valid && done_fault));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_phys == '0));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !req_ready);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_end_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end_w |=> done_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));
endmodule

bind xlat_walker3 xlat_walker3_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_present(mem_rsp_data[PRESENT_BIT]),
  .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
  .done_phys(done_phys), .accept_w(accept_w), .rsp_take_w(rsp_take_w),
  .walk_end_w(walk_end_w)
);

// File: tb/xlat_walker3_test.sv
`timescale 1ns/1ps
module xlat_walker3_test;
  localparam int LIN_W  = 32;
  localparam int PHYS_W = 36;
  localparam int ENT_W  = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              cfg_root_we;
  logic [PHYS_W-1:0] cfg_root_data;
  logic              req_valid;
  logic              req_ready;
  logic [LIN_W-1:0]  req_lin;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PHYS_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [ENT_W-1:0]  mem_rsp_data;
  logic              done_valid;
  logic              done_fault;
  logic [1:0]        done_level;
  logic [PHYS_W-1:0] done_phys;

  xlat_walker3 uut (
    .clk(clk), .rst_n(rst_n), .cfg_root_we(cfg_root_we), .cfg_root_data(cfg_root_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
    .done_phys(done_phys)
  );

  int nchk = 0;
  int nfail = 0;
  logic [ENT_W-1:0]  mem [logic [PHYS_W-1:0]];
  logic [PHYS_W-1:0] rd_log [0:7];
  int                rd_n;
  bit                stall_en;
  bit                pend;
  int                pcnt;
  logic [PHYS_W-1:0] paddr;
  logic [PHYS_W-1:0] root_cur;

  function automatic logic [ENT_W-1:0] rd(input logic [PHYS_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return '0;
  endfunction

  // Slot address for level k, written from R2/R3.
  function automatic logic [PHYS_W-1:0] slot(input logic [PHYS_W-1:0] base, input int k,
                                             input logic [LIN_W-1:0] lin);
    logic [PHYS_W-1:0] idx;
    case (k)
      0:       idx = PHYS_W'(lin >> 30);
      1:       idx = PHYS_W'((lin >> 21) & 32'h1FF);
      default: idx = PHYS_W'((lin >> 12) & 32'h1FF);
    endcase
    return base + idx * 36'd8;
  endfunction

  function automatic logic [PHYS_W-1:0] root_align(input logic [PHYS_W-1:0] r);
    return (r >> 5) << 5;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // Reference walk from R2..R6 and R9.
  task automatic ref_walk(input logic [LIN_W-1:0] lin, input logic [PHYS_W-1:0] root,
                          output bit f, output logic [1:0] lv, output logic [PHYS_W-1:0] ph,
                          output int n, output logic [PHYS_W-1:0] ad [0:2]);
    logic [PHYS_W-1:0] base;
    logic [ENT_W-1:0]  e;
    bit stop;
    base = root_align(root);
    f = 0; lv = 0; ph = 0; n = 0; stop = 0;
    for (int k = 0; k < 3; k++) begin
      ad[k] = '0;
      if (!stop) begin
        ad[k] = slot(base, k, lin);
        n = k + 1;
        e = rd(ad[k]);
        lv = 2'(k);
        if (e[0] == 1'b0) begin
          f = 1; ph = '0; stop = 1;
        end else if (k == 1 && e[7]) begin
          ph = ((PHYS_W'(e) >> 21) << 21) | PHYS_W'(lin & 32'h1F_FFFF);
          stop = 1;
        end else if (k == 2) begin
          ph = ((PHYS_W'(e) >> 12) << 12) | PHYS_W'(lin & 32'hFFF);
        end
        base = (PHYS_W'(e) >> 12) << 12;
      end
    end
  endtask

  // Lays out a walk path; pres/lg give bit 0 / bit 7 per level; bits 63:36 random (R9).
  task automatic build_path(input logic [LIN_W-1:0] lin, input logic [PHYS_W-1:0] root,
                            input logic [2:0] pres, input logic [2:0] lg);
    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] a;
    logic [23:0]       pfn;
    mem.delete();
    base = root_align(root);
    for (int k = 0; k < 3; k++) begin
      a   = slot(base, k, lin);
      pfn = 24'($urandom);
      mem[a] = {28'($urandom), pfn, 4'($urandom), lg[k], 6'($urandom), pres[k]};
      base = {pfn, 12'h000};
    end
  endtask

  task automatic set_root(input logic [PHYS_W-1:0] v);
    @(negedge clk);
    cfg_root_we = 1'b1;
    cfg_root_data = v;
    @(negedge clk);
    cfg_root_we = 1'b0;
    root_cur = v;
  endtask

  // mode: 0 plain, 1 offer a second request while busy, 2 write root mid-walk
  task automatic do_walk(input logic [LIN_W-1:0] lin, input int mode, input string tag);
    bit f; logic [1:0] lv; logic [PHYS_W-1:0] ph; int n; logic [PHYS_W-1:0] ad [0:2];
    int t;
    logic [PHYS_W-1:0] new_root;
    ref_walk(lin, root_cur, f, lv, ph, n, ad);
    new_root = {4'($urandom), 32'($urandom)};
    @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1;
    req_lin = lin;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done_valid && t < 300) begin
      if (mode == 1 && t == 0) begin
        check({tag, " R7 ready low while busy"}, 64'(req_ready), 64'd0);
        req_valid = 1'b1;
        req_lin = ~lin;
      end
      if (mode == 2) cfg_root_we = (t == 0);
      if (mode == 2 && t == 0) cfg_root_data = new_root;
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    cfg_root_we = 1'b0;
    if (mode == 2) root_cur = new_root;
    if (!done_valid) begin
      nchk++; nfail++;
      $display("FAIL %s R8 no done_valid actual=0 expected=1", tag);
      return;
    end
    check({tag, " R6 done_fault"}, 64'(done_fault), 64'(f));
    check({tag, " R5 done_level"}, 64'(done_level), 64'(lv));
    check({tag, " R4 done_phys"}, 64'(done_phys), 64'(ph));
    check({tag, " R4 read count"}, 64'(rd_n), 64'(n));
    for (int k = 0; k < 3; k++)
      if (k < n && k < rd_n)
        check({tag, (k == 0) ? " R2 read addr" : " R3 read addr"}, 64'(rd_log[k]), 64'(ad[k]));
    @(negedge clk);
    check({tag, " R8 single done pulse"}, 64'({req_ready, done_valid}), 64'b10);
    if (mode == 1) begin
      @(negedge clk);
      check({tag, " R7 ignored request started nothing"}, 64'({mem_req_valid, rd_n == n}), 64'b01);
    end
  endtask

  // Memory responder with random stalls and latency.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    pend = 0; pcnt = 0; paddr = '0; rd_n = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(paddr);
          pend = 0;
        end else pcnt--;
      end
      mem_req_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready && !pend) begin
        if (rd_n < 8) rd_log[rd_n] = mem_req_addr;
        rd_n++;
        paddr = mem_req_addr;
        pcnt = $urandom % 3;
        pend = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [LIN_W-1:0] lin;
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; cfg_root_we = 1'b0; cfg_root_data = '0;
    req_valid = 1'b0; req_lin = '0; stall_en = 0; root_cur = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset quiet", 64'({mem_req_valid, done_valid}), 64'd0);

    // R2/R9: root with low bits set; 4 KB walk; every top slot.
    set_root(36'h9_8765_4A1F);
    for (int k = 0; k < 4; k++) begin
      lin = {2'(k), 30'($urandom)};
      build_path(lin, root_cur, 3'b111, 3'b000);
      do_walk(lin, 0, "R4 full walk");
    end
    // R5: large page, and bit 7 on top and leaf entries ignored.
    lin = 32'hA5A5_5A5A;
    build_path(lin, root_cur, 3'b111, 3'b010);
    do_walk(lin, 0, "R5 large page");
    build_path(lin, root_cur, 3'b111, 3'b101);
    do_walk(lin, 0, "R5 bit7 ignored off directory");
    // R6: fault at each level.
    build_path(lin, root_cur, 3'b110, 3'b000);
    do_walk(lin, 0, "R6 fault level0");
    build_path(lin, root_cur, 3'b101, 3'b010);
    do_walk(lin, 0, "R6 fault level1");
    build_path(lin, root_cur, 3'b011, 3'b000);
    do_walk(lin, 0, "R6 fault level2");
    // R7: busy refusal; R2: root written mid-walk.
    stall_en = 1;
    lin = 32'h3FFF_FFFF;
    build_path(lin, root_cur, 3'b111, 3'b000);
    do_walk(lin, 1, "R7 busy");
    build_path(lin, root_cur, 3'b111, 3'b000);
    do_walk(lin, 2, "R2 root write mid-walk");
    build_path(lin, root_cur, 3'b111, 3'b000);
    do_walk(lin, 0, "R2 new root used");

    // Random walks.
    for (int i = 0; i < 300; i++) begin
      logic [2:0] pr;
      if (i % 50 == 0) set_root({4'($urandom), 32'($urandom)});
      pr = {($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0};
      stall_en = $urandom % 2;
      lin = $urandom;
      build_path(lin, root_cur, pr, 3'($urandom));
      do_walk(lin, (i % 25 == 7) ? 1 : 0, "R9 random walk");
    end

    summary();
    $finish;
  end
endmodule